// File: doc/BRIEF.md
# Wiper Position Controller for a 100-Tap Digital Potentiometer

This block is the digital control section of a digitally controlled potentiometer with 100 tap points. A host drives three slow pins: an active-low select, an increment strobe and a direction level. All three are synchronised to the system clock, and edges are detected after synchronisation. Each falling edge of the strobe that arrives while the block is selected moves a 7-bit wiper position one tap up or down. The position never leaves the range 0 to 99. It is decoded into a one-hot select that drives exactly one of 100 tap switches.

A register stands in for the nonvolatile cell that holds the wiper position. If select rises while the strobe is high, the current position is written into that copy and a busy interval starts; the length of the interval is set by a parameter. If select rises while the strobe is low, the copy is left as it is. The copy survives the functional reset `rst_ni`. In the first cycle after that reset, the wiper is reloaded from the copy. Only the power-on reset `por_ni` sets the copy back to a parameterised initial tap.

Top module: `wiper_ctrl`

## Requirements
- R1: After power-on reset (`por_ni` and `rst_ni` both pulsed), `pos_o` equals the parameter INIT_POS.
- R2: `tap_sel_o` has exactly one bit set, at bit index `pos_o`.
- R3: A falling edge of `inc_i` while `cs_ni` is low and `up_i` is high raises `pos_o` by one. A rising edge of `inc_i` does not move the wiper.
- R4: A falling edge of `inc_i` while `cs_ni` is low and `up_i` is low lowers `pos_o` by one.
- R5: An up step at tap 99 and a down step at tap 0 are ignored. The position never wraps.
- R6: Falling edges of `inc_i` while `cs_ni` is high leave `pos_o` unchanged.
- R7: A rising edge of `cs_ni` while `inc_i` is high stores `pos_o` into the nonvolatile copy. `busy_o` is then high for exactly STORE_CYCLES clock cycles.
- R8: A rising edge of `cs_ni` while `inc_i` is low leaves the copy unchanged and does not raise `busy_o`.
- R9: While `busy_o` is high, strobe edges do not move the wiper, and a further rising edge of select neither restarts nor lengthens the busy interval.
- R10: After `rst_ni` alone is pulsed, `pos_o` equals the last stored copy. After `por_ni` is pulsed, the copy returns to INIT_POS.
- R11: When `cs_ni` rises and `inc_i` falls in the same cycle, the wiper does not move and no store starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous functional reset; triggers a recall |
| por_ni | input | 1 | Active-low power-on reset of the nonvolatile copy |
| cs_ni | input | 1 | Active-low select (asynchronous) |
| inc_i | input | 1 | Increment strobe; wiper moves on its falling edge (asynchronous) |
| up_i | input | 1 | Direction: 1 toward tap 99, 0 toward tap 0 (asynchronous) |
| pos_o | output | 7 | Current wiper tap |
| tap_sel_o | output | 100 | One-hot tap switch select |
| busy_o | output | 1 | Store in progress |

## Verification
Two events can land in the same cycle: the deselect edge that decides whether to store, and the strobe fall that would step the wiper. The bench provokes this by changing `cs_ni` and `inc_i` on the same clock. Because both pass through synchronisers of equal depth, the edges are detected together. The bench then checks that the wiper holds, that `busy_o` stays low, and, after a functional reset, that the recalled tap is still the previously stored one. A store whose busy interval overlaps a new select cycle is judged the same way: the wiper must not move, and the interval must last exactly STORE_CYCLES.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  parameter int unsigned DEF_TAPS = 100;

  typedef struct packed {
    logic cs_n;
    logic inc;
    logic up;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, inc: 1'b1, up: 1'b0};
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[b] <= RST_VAL[b];
        s2_q[b] <= RST_VAL[b];
      end else begin
        s1_q[b] <= d_i[b];
        s2_q[b] <= s1_q[b];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
  parameter int unsigned TAPS  = 100,
  localparam int unsigned POS_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic             load_i,
  input  logic [POS_W-1:0] load_val_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] MAX_POS = POS_W'(TAPS - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (load_i) begin
      pos_q <= load_val_i;
    end else if (step_up_i && pos_q != MAX_POS) begin
      pos_q <= pos_q + POS_W'(1);
    end else if (step_dn_i && pos_q != '0) begin
      pos_q <= pos_q - POS_W'(1);
    end
  end

  assign pos_o = pos_q;

  a_r5_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= MAX_POS);
  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_up_i && !load_i && pos_q != MAX_POS |=> pos_q == $past(pos_q) + POS_W'(1));
  a_r4_step_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_dn_i && !step_up_i && !load_i && pos_q != '0 |=> pos_q == $past(pos_q) - POS_W'(1));
  a_r5_clamp_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_up_i && !load_i && pos_q == MAX_POS |=> pos_q == MAX_POS);
  a_r5_clamp_bot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_dn_i && !step_up_i && !load_i && pos_q == '0 |=> pos_q == '0);
endmodule

// File: rtl/wiper_decoder.sv
module wiper_decoder #(
  parameter int unsigned TAPS  = 100,
  localparam int unsigned POS_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] pos_i,
  output logic [TAPS-1:0]  sel_o
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign sel_o[t] = (pos_i == POS_W'(t));
  end

  a_r2_one_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1 && sel_o[pos_i]);
endmodule

// File: rtl/wiper_nv.sv
module wiper_nv #(
  parameter int unsigned TAPS         = 100,
  parameter int unsigned INIT_POS     = 0,
  parameter int unsigned STORE_CYCLES = 2_500_000,
  localparam int unsigned POS_W = $clog2(TAPS),
  localparam int unsigned CNT_W = $clog2(STORE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             store_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] nv_o,
  output logic             busy_o,
  output logic             recall_o
);
  logic [POS_W-1:0] nv_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             recall_q;
  logic             start;

  assign start = store_i && !busy_q;

  // copy survives the functional reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      nv_q <= POS_W'(INIT_POS);
    end else if (rst_ni && start) begin
      nv_q <= pos_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      recall_q <= 1'b1;
    end else begin
      recall_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(STORE_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign nv_o     = nv_q;
  assign busy_o   = busy_q;
  assign recall_o = recall_q;

  a_r7_store_busy: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    store_i && !busy_q |=> busy_q && nv_q == $past(pos_i));
  a_r8_copy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !store_i |=> $stable(nv_q));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    busy_q && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - CNT_W'(1) && $stable(nv_q));
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int unsigned TAPS         = DEF_TAPS,
  parameter int unsigned INIT_POS     = 0,
  parameter int unsigned STORE_CYCLES = 2_500_000,
  localparam int unsigned POS_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             cs_ni,
  input  logic             inc_i,
  input  logic             up_i,
  output logic [POS_W-1:0] pos_o,
  output logic [TAPS-1:0]  tap_sel_o,
  output logic             busy_o
);
  ctl_t ctl_raw, ctl_s, ctl_prev_q;
  logic inc_fall, cs_rise, step_ok, store_req, recall;
  logic [POS_W-1:0] pos, nv_pos;

  assign ctl_raw = '{cs_n: cs_ni, inc: inc_i, up: up_i};

  wiper_sync #(.W($bits(ctl_t)), .RST_VAL(CTL_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_prev_q <= CTL_IDLE;
    else         ctl_prev_q <= ctl_s;
  end

  assign inc_fall  = ctl_prev_q.inc && !ctl_s.inc;
  assign cs_rise   = !ctl_prev_q.cs_n && ctl_s.cs_n;
  assign step_ok   = inc_fall && !ctl_s.cs_n && !busy_o && !recall;
  // store only if the strobe is high as select rises
  assign store_req = cs_rise && ctl_s.inc;

  wiper_nv #(.TAPS(TAPS), .INIT_POS(INIT_POS), .STORE_CYCLES(STORE_CYCLES)) u_nv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .por_ni  (por_ni),
    .store_i (store_req),
    .pos_i   (pos),
    .nv_o    (nv_pos),
    .busy_o  (busy_o),
    .recall_o(recall)
  );

  wiper_counter #(.TAPS(TAPS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_up_i (step_ok && ctl_s.up),
    .step_dn_i (step_ok && !ctl_s.up),
    .load_i    (recall),
    .load_val_i(nv_pos),
    .pos_o     (pos)
  );

  wiper_decoder #(.TAPS(TAPS)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pos_i (pos),
    .sel_o (tap_sel_o)
  );

  assign pos_o = pos;

  a_r6_desel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_s.cs_n && !recall |=> $stable(pos));
  a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pos));
  a_r10_recall: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    recall |=> pos == $past(nv_pos));
  a_r11_collide: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    cs_rise && inc_fall && !busy_o |=> !busy_o && $stable(pos));
endmodule

// File: tb/wiper_ctrl_tb.sv
module wiper_ctrl_tb;
  localparam int TAPS = 100;
  localparam int INIT = 37;
  localparam int STORE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic cs_n = 1'b1, inc = 1'b1, up = 1'b0;
  logic [6:0] pos;
  logic [TAPS-1:0] tap_sel;
  logic busy;

  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  int exp_pos, exp_nv;
  bit done = 0;

  always #4 clk = ~clk;

  wiper_ctrl #(.TAPS(TAPS), .INIT_POS(INIT), .STORE_CYCLES(STORE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .cs_ni(cs_n), .inc_i(inc),
    .up_i(up), .pos_o(pos), .tap_sel_o(tap_sel), .busy_o(busy)
  );

  always @(negedge clk) if (busy) busy_cnt++;

  function automatic int model_step(int p, bit dir);
    if (dir) return (p < TAPS - 1) ? p + 1 : p;
    return (p > 0) ? p - 1 : p;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    logic [TAPS-1:0] exp_sel;
    exp_sel = '0;
    exp_sel[exp_pos] = 1'b1;
    chk(req, "pos", int'(pos), exp_pos);
    chk("R2", "tap_sel match", int'(tap_sel == exp_sel), 1);
  endtask

  // selected step: move by model
  task automatic step(bit dir);
    up = dir; wait_cyc(2);
    inc = 1'b0; wait_cyc(5);
    inc = 1'b1; wait_cyc(5);
    exp_pos = model_step(exp_pos, dir);
  endtask

  task automatic func_reset();
    rst_n = 1'b0; wait_cyc(2);
    rst_n = 1'b1; wait_cyc(5);
    exp_pos = exp_nv;
  endtask

  task automatic store_cycle(string req);
    busy_cnt = 0;
    cs_n = 1'b1; wait_cyc(STORE + 10);
    exp_nv = exp_pos;
    chk(req, "busy cycles", busy_cnt, STORE);
    cs_n = 1'b0; wait_cyc(5);
  endtask

  // deselect with strobe low: the strobe fall itself is a selected step
  task automatic nostore_cycle(string req);
    inc = 1'b0; wait_cyc(5);
    exp_pos = model_step(exp_pos, up);
    busy_cnt = 0;
    cs_n = 1'b1; wait_cyc(5);
    inc = 1'b1; wait_cyc(5);
    inc = 1'b0; wait_cyc(5);
    inc = 1'b1; wait_cyc(5);
    chk(req, "busy cycles", busy_cnt, 0);
    chk_state("R6");
    cs_n = 1'b0; wait_cyc(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(3);
    por_n = 1'b1; rst_n = 1'b1; wait_cyc(5);
    exp_nv = INIT; exp_pos = INIT;
    chk_state("R1");
    chk("R7", "busy idle", int'(busy), 0);

    cs_n = 1'b0; wait_cyc(5);
    step(1'b1); step(1'b1); step(1'b1);
    chk_state("R3");
    step(1'b0);
    chk_state("R4");

    // R3: strobe rise alone does not move
    up = 1'b1; inc = 1'b0; wait_cyc(5);
    exp_pos = model_step(exp_pos, 1'b1);
    chk_state("R3");
    inc = 1'b1; wait_cyc(5);
    chk_state("R3");

    for (int i = 0; i < 70; i++) step(1'b1);
    chk("R5", "top clamp", int'(pos), 99);
    chk_state("R5");
    for (int i = 0; i < 105; i++) step(1'b0);
    chk("R5", "bottom clamp", int'(pos), 0);
    chk_state("R5");
    for (int i = 0; i < 5; i++) step(1'b1);
    chk_state("R3");

    store_cycle("R7");
    step(1'b1); step(1'b1); step(1'b1);
    chk_state("R3");
    func_reset();
    chk_state("R10");
    cs_n = 1'b0; wait_cyc(5);

    up = 1'b1;
    nostore_cycle("R8");
    func_reset();
    chk_state("R8");
    cs_n = 1'b0; wait_cyc(5);

    // R9: select cycle inside busy window
    step(1'b1);
    busy_cnt = 0;
    cs_n = 1'b1; wait_cyc(4);
    exp_nv = exp_pos;
    chk("R9", "busy started", int'(busy), 1);
    cs_n = 1'b0; wait_cyc(3);
    inc = 1'b0; wait_cyc(3);
    inc = 1'b1; wait_cyc(3);
    cs_n = 1'b1; wait_cyc(STORE + 10);
    chk("R9", "busy cycles", busy_cnt, STORE);
    chk_state("R9");
    cs_n = 1'b0; wait_cyc(5);

    // R11: select rise and strobe fall together
    step(1'b1);
    busy_cnt = 0;
    inc = 1'b0; cs_n = 1'b1; wait_cyc(6);
    chk_state("R11");
    chk("R11", "busy cycles", busy_cnt, 0);
    inc = 1'b1; wait_cyc(4);
    func_reset();
    chk_state("R11");
    cs_n = 1'b0; wait_cyc(5);

    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 5) begin
        step(1'($urandom_range(0, 1)));
        chk_state(up ? "R3" : "R4");
      end else if (op == 6) begin
        up = 1'($urandom_range(0, 1));
        nostore_cycle("R8");
      end else if (op == 7) begin
        store_cycle("R7");
        chk_state("R7");
      end else begin
        func_reset();
        chk_state("R10");
        cs_n = 1'b0; wait_cyc(5);
      end
    end

    por_n = 1'b0; rst_n = 1'b0; wait_cyc(2);
    por_n = 1'b1; rst_n = 1'b1; wait_cyc(5);
    exp_nv = INIT; exp_pos = INIT;
    chk_state("R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule